// File: doc/BRIEF.md
# Idle-Timed Power-Down Controller

This block manages power for a programmable logic device that sits on a host bus. The host programs an 8-bit mode register through a single-cycle write port. The register sets four things: whether automatic power-down is armed, whether turbo mode is on, and whether the input clock reaches the logic array and the macrocells. When power-down is armed, the block watches the address-latch strobe. After a fixed run of input clocks with no strobe activity, it raises a power-down flag. The next strobe clears that flag again.

Two resets reach the block, and they do different jobs. A power-on reset brings everything to a known state, including the mode register. The ordinary reset pulse only sets the idle timer and the power-down flag back to their starting values. The programmed mode therefore survives a system reset. The three clock-gate and turbo controls are registered copies of the mode bits, so they only ever change on an input clock edge.

Top module: `idle_pdn_ctrl`

## Requirements
- R1: While `por_n` is low at a rising edge, the mode register clears to 0x00, `pdn` goes low, and `turbo_on`, `array_clk_en` and `mcell_clk_en` all go to 1.
- R2: A rising edge with `rst_n` low clears `pdn` and the idle count. It leaves `reg_rdata` unchanged and has no effect on the three gate outputs.
- R3: A write (`reg_we` high at a rising edge) stores only bits 1, 3, 4 and 5 of `reg_wdata`. `reg_rdata` always shows bits 0, 2, 6 and 7 as zero.
- R4: With bit 1 of the register set, `pdn` rises after exactly 15 consecutive rising edges with `strobe` low. It is still low after 14 such edges.
- R5: While bit 1 of the register reads 0, `pdn` stays low no matter how long `strobe` stays idle.
- R6: A rising edge with `strobe` high clears the idle count, so a new run of 15 idle edges is needed.
- R7: If `pdn` is high and `strobe` is high at a rising edge, `pdn` is low after that edge.
- R8: If bit 1 is cleared while `pdn` is high, `pdn` is low one clock after `reg_rdata` first shows bit 1 as 0.
- R9: `turbo_on` equals the inverse of register bit 3 as it stood one clock earlier.
- R10: `array_clk_en` equals the inverse of register bit 4 as it stood one clock earlier.
- R11: `mcell_clk_en` equals the inverse of register bit 5 as it stood one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, which also counts idle time |
| por_n | input | 1 | Power-on reset, synchronous, active low |
| rst_n | input | 1 | System reset pulse, synchronous, active low; does not touch the mode register |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register readback |
| strobe | input | 1 | Address-latch strobe; high means bus activity |
| pdn | output | 1 | Power-down state flag |
| turbo_on | output | 1 | Turbo mode active |
| array_clk_en | output | 1 | Clock-gate enable for the logic array |
| mcell_clk_en | output | 1 | Clock-gate enable for the macrocells |

## Verification
The idle timer is tested with four kinds of strobe pattern:
- An unbroken idle run, which checks the exact 15-edge threshold.
- An idle run cut by a single strobe part way through, which shows that the count restarts rather than pauses.
- A strobe while powered down, which checks the wake path.
- A long idle run with the enable bit cleared, which checks that power-down stays off.

Reset pulses are applied while the block is powered down and the register holds a nonzero value. These tell apart the two reset scopes. Single-bit register writes confirm that each gate output follows its own bit one clock later.

// File: rtl/idle_pdn_pkg.sv
// Package: shared widths, bit positions and field type for the idle power-down
// controller. Bit positions are visible to host software and must not move.
package idle_pdn_pkg;
    localparam int unsigned MODE_W        = 8;
    localparam int unsigned BIT_AUTO_PDN  = 1;
    localparam int unsigned BIT_TURBO_OFF = 3;
    localparam int unsigned BIT_ARRAY_OFF = 4;
    localparam int unsigned BIT_MCELL_OFF = 5;
    localparam int unsigned N_GATES       = 3;

    localparam logic [MODE_W-1:0] MODE_MASK =
        MODE_W'((1 << BIT_AUTO_PDN) | (1 << BIT_TURBO_OFF) |
                (1 << BIT_ARRAY_OFF) | (1 << BIT_MCELL_OFF));

    typedef struct packed {
        logic auto_pdn;
        logic turbo_off;
        logic array_off;
        logic mcell_off;
    } mode_fields_t;
endpackage

// File: rtl/pdn_mode_reg.sv
// Mode register. Holds the host-programmed mode byte with unused bits forced
// to zero. Assumes por_n is a synchronous active-low power-on reset; the
// system reset pulse is deliberately not an input here.
module pdn_mode_reg
    import idle_pdn_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_q,
    output mode_fields_t      fields
);
    // Store masked write data; only power-on clears the register.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            mode_q <= '0;
        end else if (we) begin
            mode_q <= wdata & MODE_MASK;
        end
    end

    // Decode the named fields from the stored byte.
    always_comb begin
        fields.auto_pdn  = mode_q[BIT_AUTO_PDN];
        fields.turbo_off = mode_q[BIT_TURBO_OFF];
        fields.array_off = mode_q[BIT_ARRAY_OFF];
        fields.mcell_off = mode_q[BIT_MCELL_OFF];
    end
endmodule

// File: rtl/pdn_idle_timer.sv
// Idle timer and power-down state. Counts rising edges with the strobe low
// while enabled and sets the power-down flag when the count reaches
// IDLE_CYCLES. Strobe activity, a cleared enable or either reset returns it
// to the active state. Assumes strobe is synchronous to clk.
module pdn_idle_timer #(
    parameter int unsigned IDLE_CYCLES = 15
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    output logic pdn
);
    localparam int unsigned CNT_W = $clog2(IDLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IDLE_CYCLES - 1);

    logic [CNT_W-1:0] idle_cnt;
    logic             pdn_q;

    // Advance the idle count and enter or leave power-down.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            idle_cnt <= '0;
            pdn_q    <= 1'b0;
        end else if (!enable || strobe) begin
            idle_cnt <= '0;
            pdn_q    <= 1'b0;
        end else if (!pdn_q) begin
            if (idle_cnt == LAST) begin
                pdn_q <= 1'b1;
            end
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign pdn = pdn_q;
endmodule

// File: rtl/pdn_gate_out.sv
// Registered gate controls. Each output is the inverse of its "off" bit,
// captured on the input clock so gating changes only at clock edges. Power-on
// sets every control to its active (1) level; the system reset does not
// touch them.
module pdn_gate_out
    import idle_pdn_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic [N_GATES-1:0] off_bits,
    output logic [N_GATES-1:0] en_q
);
    for (genvar g = 0; g < N_GATES; g++) begin : g_gate
        logic q;
        // Capture one inverted control bit per clock.
        always_ff @(posedge clk) begin
            if (!por_n) begin
                q <= 1'b1;
            end else begin
                q <= ~off_bits[g];
            end
        end
        assign en_q[g] = q;
    end
endmodule

// File: rtl/idle_pdn_ctrl.sv
// Top level of the idle power-down controller. Connects the mode register,
// the idle timer and the gate controls. All inputs are assumed synchronous to
// clk; both resets are synchronous and active low.
module idle_pdn_ctrl
    import idle_pdn_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 15
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [MODE_W-1:0] reg_wdata,
    output logic [MODE_W-1:0] reg_rdata,
    input  logic              strobe,
    output logic              pdn,
    output logic              turbo_on,
    output logic              array_clk_en,
    output logic              mcell_clk_en
);
    mode_fields_t       fields;
    logic [N_GATES-1:0] off_bits;
    logic [N_GATES-1:0] gate_en;

    pdn_mode_reg u_reg (
        .clk    (clk),
        .por_n  (por_n),
        .we     (reg_we),
        .wdata  (reg_wdata),
        .mode_q (reg_rdata),
        .fields (fields)
    );

    pdn_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_timer (
        .clk    (clk),
        .por_n  (por_n),
        .rst_n  (rst_n),
        .enable (fields.auto_pdn),
        .strobe (strobe),
        .pdn    (pdn)
    );

    // Order the off bits as turbo, array, macrocell for the gate bank.
    always_comb begin
        off_bits = {fields.mcell_off, fields.array_off, fields.turbo_off};
    end

    pdn_gate_out u_gates (
        .clk      (clk),
        .por_n    (por_n),
        .off_bits (off_bits),
        .en_q     (gate_en)
    );

    assign turbo_on     = gate_en[0];
    assign array_clk_en = gate_en[1];
    assign mcell_clk_en = gate_en[2];
endmodule

// File: rtl/idle_pdn_chk.sv
// Checker for idle_pdn_ctrl. Keeps its own count of idle edges to check the
// power-down threshold without reproducing the design's timer.
module idle_pdn_chk
    import idle_pdn_pkg::*;
#(
    parameter int unsigned IDLE_CYCLES = 15
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              reg_we,
    input logic [MODE_W-1:0] reg_rdata,
    input logic              strobe,
    input logic              pdn,
    input logic              turbo_on,
    input logic              array_clk_en,
    input logic              mcell_clk_en
);
    localparam int unsigned RUN_W = $clog2(IDLE_CYCLES + 1);
    logic [RUN_W-1:0] run_q;

    // Count the idle edges that qualify, saturating at the threshold.
    always_ff @(posedge clk) begin
        if (!por_n || !rst_n || !reg_rdata[BIT_AUTO_PDN] || strobe) begin
            run_q <= '0;
        end else if (int'(run_q) < IDLE_CYCLES) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_unused_zero_R3: assert property (@(posedge clk) disable iff (!por_n)
        (reg_rdata & ~MODE_MASK) == '0);

    assert_idle_threshold_R4: assert property (@(posedge clk) disable iff (!por_n)
        pdn == (int'(run_q) == IDLE_CYCLES));

    assert_disabled_R5: assert property (@(posedge clk) disable iff (!por_n)
        !reg_rdata[BIT_AUTO_PDN] |=> !pdn);

    assert_wake_R7: assert property (@(posedge clk) disable iff (!por_n)
        (pdn && strobe) |=> !pdn);

    assert_reset_keeps_reg_R2: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n && !reg_we) |=> $stable(reg_rdata));

    assert_reset_clears_pdn_R2: assert property (@(posedge clk) disable iff (!por_n)
        !rst_n |=> !pdn);

    assert_turbo_R9: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (turbo_on == !$past(reg_rdata[BIT_TURBO_OFF])));

    assert_array_R10: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (array_clk_en == !$past(reg_rdata[BIT_ARRAY_OFF])));

    assert_mcell_R11: assert property (@(posedge clk) disable iff (!por_n)
        1'b1 |=> (mcell_clk_en == !$past(reg_rdata[BIT_MCELL_OFF])));
endmodule

bind idle_pdn_ctrl idle_pdn_chk #(.IDLE_CYCLES(IDLE_CYCLES)) u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .rst_n        (rst_n),
    .reg_we       (reg_we),
    .reg_rdata    (reg_rdata),
    .strobe       (strobe),
    .pdn          (pdn),
    .turbo_on     (turbo_on),
    .array_clk_en (array_clk_en),
    .mcell_clk_en (mcell_clk_en)
);

// File: tb/tb_idle_pdn_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver computes the expected outputs from the
// requirements and queues them; the monitor compares them after each edge.
module tb_idle_pdn_ctrl;
    localparam int unsigned LIMIT = 15;
    localparam logic [7:0]  MASK  = 8'h3A;

    logic       clk = 1'b0;
    logic       por_n = 1'b0, rst_n = 1'b1, reg_we = 1'b0, strobe = 1'b1;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       pdn, turbo_on, array_clk_en, mcell_clk_en;

    typedef struct {
        logic [7:0] rdata;
        logic       pdn;
        logic       turbo;
        logic       arr;
        logic       mc;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    // Reference state, derived from the requirements.
    logic [7:0] m_reg = 8'h00;
    int         m_cnt = 0;
    logic       m_pdn = 1'b0;
    logic       m_turbo = 1'b1, m_arr = 1'b1, m_mc = 1'b1;

    always #2 clk = ~clk;

    idle_pdn_ctrl dut (
        .clk          (clk),
        .por_n        (por_n),
        .rst_n        (rst_n),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .strobe       (strobe),
        .pdn          (pdn),
        .turbo_on     (turbo_on),
        .array_clk_en (array_clk_en),
        .mcell_clk_en (mcell_clk_en)
    );

    // Drive one cycle, predict the post-edge outputs, queue them and wait.
    task automatic step(input logic p, input logic r, input logic we,
                        input logic [7:0] wd, input logic s, input string tag);
        logic [7:0] old;
        exp_t e;
        por_n = p; rst_n = r; reg_we = we; reg_wdata = wd; strobe = s;
        old = m_reg;
        if (!p) begin
            m_reg = 8'h00; m_cnt = 0; m_pdn = 1'b0;
            m_turbo = 1'b1; m_arr = 1'b1; m_mc = 1'b1;
        end else begin
            m_turbo = ~old[3]; m_arr = ~old[4]; m_mc = ~old[5];
            if (we) m_reg = wd & MASK;
            if (!r || !old[1] || s) begin
                m_cnt = 0; m_pdn = 1'b0;
            end else if (!m_pdn) begin
                m_cnt++;
                if (m_cnt == LIMIT) m_pdn = 1'b1;
            end
        end
        e.rdata = m_reg; e.pdn = m_pdn; e.turbo = m_turbo;
        e.arr = m_arr; e.mc = m_mc; e.tag = tag;
        q.push_back(e);
        @(posedge clk);
        #2;
    endtask

    task automatic cmp(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Monitor: pop one expectation per edge and compare every output.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            cmp(e.tag, "reg_rdata", reg_rdata, e.rdata);
            cmp(e.tag, "pdn", {7'd0, pdn}, {7'd0, e.pdn});
            cmp(e.tag, "turbo_on", {7'd0, turbo_on}, {7'd0, e.turbo});
            cmp(e.tag, "array_clk_en", {7'd0, array_clk_en}, {7'd0, e.arr});
            cmp(e.tag, "mcell_clk_en", {7'd0, mcell_clk_en}, {7'd0, e.mc});
        end
    end

    initial begin
        #3;
        // R1: power-on state
        for (int i = 0; i < 3; i++) step(0, 1, 0, 8'h00, 1, "R1");
        step(1, 1, 0, 8'h00, 1, "R1");
        // R3: only bits 1,3,4,5 are stored
        step(1, 1, 1, 8'hFF, 1, "R3");
        step(1, 1, 0, 8'h00, 1, "R9_R10_R11");
        step(1, 1, 1, 8'h02, 1, "R3");
        // R4: exact 15-edge threshold
        for (int i = 0; i < 17; i++) step(1, 1, 0, 8'h00, 0, "R4");
        // R7: strobe wakes
        step(1, 1, 0, 8'h00, 1, "R7");
        // R6: interrupted run restarts the count
        for (int i = 0; i < 8; i++) step(1, 1, 0, 8'h00, 0, "R6");
        step(1, 1, 0, 8'h00, 1, "R6");
        for (int i = 0; i < 16; i++) step(1, 1, 0, 8'h00, 0, "R6");
        // R2: reset pulse in power-down keeps register, clears pdn
        step(1, 1, 1, 8'h3A, 0, "R2");
        step(1, 0, 0, 8'h00, 0, "R2");
        step(1, 0, 0, 8'h00, 0, "R2");
        for (int i = 0; i < 16; i++) step(1, 1, 0, 8'h00, 0, "R2");
        // R8: clearing enable while powered down
        step(1, 1, 1, 8'h38, 0, "R8");
        step(1, 1, 0, 8'h00, 0, "R8");
        // R5: disabled, long idle run
        for (int i = 0; i < 25; i++) step(1, 1, 0, 8'h00, 0, "R5");
        // R9, R10, R11: single-bit writes
        step(1, 1, 1, 8'h08, 1, "R9");
        step(1, 1, 1, 8'h10, 1, "R9_R10");
        step(1, 1, 1, 8'h20, 1, "R10_R11");
        step(1, 1, 1, 8'h00, 1, "R11");
        step(1, 1, 0, 8'h00, 1, "R11");
        // R1: power-on clears the register
        step(1, 1, 1, 8'h3A, 1, "R1");
        step(0, 1, 0, 8'h00, 1, "R1");
        step(1, 1, 0, 8'h00, 1, "R1");
        @(posedge clk);
        #2;
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule